// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is an 8-bit timer with one compare channel. A count register advances on each timer tick. When the count equals the active compare value, the block raises a sticky flag and updates an internal waveform bit. The update sets, clears or toggles the bit, as the output mode field selects. Three counting modes are available: free-running up-count, clear-on-match, and phase-correct PWM. In phase-correct PWM the counter runs up to 255 and then back down to 0.

Software reaches the block through a small register port with four addresses:

| Address | Register | Fields |
|---|---|---|
| 0 | control | bits [1:0] waveform mode, bits [3:2] output mode, bit 7 force strobe |
| 1 | count | counter value |
| 2 | compare | compare value as software sees it |
| 3 | flag | bit 0 match flag |

In PWM mode, compare writes are buffered and reach the active comparator only at the top of the count. A count write suppresses the match on the next tick, so software can preload count and compare to the same value without a spurious event. A nonzero output mode hands the port pin over from the general port data bit to the waveform bit.

Top module: `tmr_ocmp_top`

## Requirements
- R1: After reset, every register reads 0. The waveform bit is 0, and with output mode 00 `pin_out` follows `port_out`.
- R2: With waveform mode 00, the count rises by one on each tick and wraps from 255 to 0.
- R3: A match is a tick on which count equals the active compare value. A match sets the flag (address 3, bit 0), and the flag stays set until software writes 1 to that bit. Output mode sets the action on a match in mode 00 or 01: 00 does nothing, 01 toggles, 10 clears, 11 sets.
- R4: With waveform mode 01, a match tick loads the count with 0 instead of incrementing it.
- R5: A write to the count register loads it, and the first tick after that write produces no match. This holds however many idle cycles pass before that tick.
- R6: In waveform mode 00 or 01, writing control with bit 7 set applies the output action of the written output mode to the waveform bit. The flag and the count do not change, and bit 7 reads back as 0. If bit 1 of the written mode is 1, the strobe has no effect.
- R7: Waveform modes 10 and 11 are phase-correct PWM. The count rises to 255, then falls to 0, then rises again. On a match, output mode 10 clears the bit while counting up and sets it while counting down, 11 does the reverse, and 01 toggles.
- R8: In PWM modes, a compare write goes only to the buffer, which is what reads back. The buffer is copied to the active value on the tick where the count is 255. In modes 00 and 01, a compare write takes effect at once.
- R9: `pin_out` shows the waveform bit whenever output mode is nonzero, and shows `port_out` otherwise. A change of output mode acts in the next cycle, and `pin_oe` equals `port_dir`.
- R10: The waveform bit keeps its value when the waveform mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable, one pulse per count step |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| port_out | input | 1 | General port data bit |
| port_dir | input | 1 | Port direction, 1 = output |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
A vector table tries several patterns in the up-counting and clear-on-match modes:
- a match reached after a few ticks, which separates the set, clear and toggle actions;
- a match at the wrap from 255 to 0;
- a compare value that is never reached, which shows that no false flag appears;
- a preload of count equal to compare, which separates a blocked match from a taken one;
- two matches in clear-on-match mode, which show the restart and a second toggle.

Directed runs then follow one PWM sweep past the top of the count. That sweep separates a buffered compare write from a direct one and an up-count action from a down-count action. Further directed runs cover the force strobe in both mode families and hand the pin back to the port bit.

// File: rtl/tmr_pkg.sv
// Package: shared types, register addresses and the output-action rule for
// the timer compare unit. Assumes a data width of at least 8 bits.
package tmr_pkg;

    typedef enum logic [1:0] {
        OM_OFF = 2'b00,
        OM_TOG = 2'b01,
        OM_CLR = 2'b10,
        OM_SET = 2'b11
    } om_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_CMP  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int CTRL_FORCE_BIT = 7;

    // Next waveform bit for a match; PWM direction flips set/clear.
    function automatic logic oc_next(om_e om, logic pwm, logic up, logic cur);
        logic r;
        case (om)
            OM_TOG:  r = ~cur;
            OM_CLR:  r = pwm ? ~up : 1'b0;
            OM_SET:  r = pwm ? up : 1'b1;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
// Counter: holds the count, its PWM direction and the one-tick match block
// armed by a count write. Produces the qualified match event and the top
// marker used for compare buffer reloads. Assumes tick is a one-cycle pulse.
module tmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic         ctc,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] ocr_act,
    output logic [W-1:0] cnt,
    output logic         up,
    output logic         match,
    output logic         at_top
);

    localparam logic [W-1:0] TOP    = '1;
    localparam logic [W-1:0] BOTTOM = '0;

    logic [W-1:0] cnt_q;
    logic         up_q;
    logic         blk_q;
    logic         step;

    assign step   = tick && !cnt_wr;
    assign match  = step && !blk_q && (cnt_q == ocr_act);
    assign at_top = step && pwm && (cnt_q == TOP);
    assign cnt    = cnt_q;
    assign up     = up_q;

    // Count register: load, PWM sweep, clear-on-match or plain increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wdata;
        else if (tick) begin
            if (pwm) begin
                if (up_q)
                    cnt_q <= (cnt_q == TOP) ? TOP - 1'b1 : cnt_q + 1'b1;
                else
                    cnt_q <= (cnt_q == BOTTOM) ? BOTTOM + 1'b1 : cnt_q - 1'b1;
            end else if (ctc && match)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Direction: turns at top and bottom in PWM, forced up otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwm)
            up_q <= 1'b1;
        else if (step) begin
            if (up_q && cnt_q == TOP)
                up_q <= 1'b0;
            else if (!up_q && cnt_q == BOTTOM)
                up_q <= 1'b1;
        end
    end

    // Match block: armed by a count write, consumed by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= 1'b0;
        else if (cnt_wr)
            blk_q <= 1'b1;
        else if (tick)
            blk_q <= 1'b0;
    end

    // R5
    count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(wdata));

    // R2
    normal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && !ctc && step) |=> cnt_q == W'($past(cnt_q) + 1'b1));

    // R4
    ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && ctc && match) |=> cnt_q == '0);

endmodule

// File: rtl/tmr_ocr.sv
// Compare store: buffer register seen by software plus the active value the
// comparator uses. Outside PWM both follow writes at once; in PWM the active
// value reloads from the buffer only at the top of the count.
module tmr_ocr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwm,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    input  logic         at_top,
    output logic [W-1:0] ocr_act,
    output logic [W-1:0] ocr_buf
);

    logic [W-1:0] act_q;
    logic [W-1:0] buf_q;

    assign ocr_act = act_q;
    assign ocr_buf = buf_q;

    // Buffer: takes every compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_q <= '0;
        else if (cmp_wr)
            buf_q <= wdata;
    end

    // Active value: direct write outside PWM, top-of-count reload in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (cmp_wr && !pwm)
            act_q <= wdata;
        else if (at_top)
            act_q <= buf_q;
    end

    // R8
    top_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_top |=> act_q == $past(buf_q));

    // R8
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr && !pwm) |=> act_q == $past(wdata));

endmodule

// File: rtl/tmr_wave.sv
// Waveform stage: the internal compare output bit, the sticky match flag and
// the pin source select. Assumes force and flag clear never share a cycle
// (both come from the single register write port).
module tmr_wave
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  om_e  om,
    input  logic pwm,
    input  logic up,
    input  logic match,
    input  logic force_ev,
    input  om_e  force_om,
    input  logic flag_clr,
    input  logic port_out,
    input  logic port_dir,
    output logic flag,
    output logic pin_out,
    output logic pin_oe
);

    logic oc_q;
    logic flag_q;

    assign flag    = flag_q;
    assign pin_out = (om != OM_OFF) ? oc_q : port_out;
    assign pin_oe  = port_dir;

    // Output bit: real match action first, then forced action.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oc_q <= 1'b0;
        else if (match)
            oc_q <= oc_next(om, pwm, up, oc_q);
        else if (force_ev)
            oc_q <= oc_next(force_om, 1'b0, 1'b1, oc_q);
    end

    // Flag: set by a match, cleared by software writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (match)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end

    // R6
    force_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_ev && !match) |=> $stable(flag_q));

    // R3
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/tmr_ocmp_top.sv
// Top: register port decode and readback for the compare timer, wiring the
// counter, compare store and waveform stage. Assumes W >= 8 so that the
// control fields fit; reads are combinational on reg_addr.
module tmr_ocmp_top
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reg_we,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         port_out,
    input  logic         port_dir,
    output logic         pin_out,
    output logic         pin_oe
);

    logic [1:0]   wm_q;
    om_e          om_q;
    logic         pwm;
    logic         ctc;
    logic         ctrl_wr;
    logic         cnt_wr;
    logic         cmp_wr;
    logic         flag_clr;
    logic         force_ev;
    om_e          force_om;
    logic [W-1:0] cnt;
    logic         up;
    logic         match;
    logic         at_top;
    logic [W-1:0] ocr_act;
    logic [W-1:0] ocr_buf;
    logic         flag;

    assign pwm      = wm_q[1];
    assign ctc      = (wm_q == 2'b01);
    assign ctrl_wr  = reg_we && (reg_addr == ADDR_CTRL);
    assign cnt_wr   = reg_we && (reg_addr == ADDR_CNT);
    assign cmp_wr   = reg_we && (reg_addr == ADDR_CMP);
    assign flag_clr = reg_we && (reg_addr == ADDR_FLAG) && reg_wdata[0];
    assign force_ev = ctrl_wr && reg_wdata[CTRL_FORCE_BIT] && !reg_wdata[1];
    assign force_om = om_e'(reg_wdata[3:2]);

    // Control register: waveform mode and output mode, both unbuffered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q <= 2'b00;
            om_q <= OM_OFF;
        end else if (ctrl_wr) begin
            wm_q <= reg_wdata[1:0];
            om_q <= om_e'(reg_wdata[3:2]);
        end
    end

    // Readback mux; the force strobe always reads zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: reg_rdata[3:0] = {om_q, wm_q};
            ADDR_CNT:  reg_rdata      = cnt;
            ADDR_CMP:  reg_rdata      = ocr_buf;
            default:   reg_rdata[0]   = flag;
        endcase
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .pwm     (pwm),
        .ctc     (ctc),
        .cnt_wr  (cnt_wr),
        .wdata   (reg_wdata),
        .ocr_act (ocr_act),
        .cnt     (cnt),
        .up      (up),
        .match   (match),
        .at_top  (at_top)
    );

    tmr_ocr #(.W(W)) u_ocr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm     (pwm),
        .cmp_wr  (cmp_wr),
        .wdata   (reg_wdata),
        .at_top  (at_top),
        .ocr_act (ocr_act),
        .ocr_buf (ocr_buf)
    );

    tmr_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .om       (om_q),
        .pwm      (pwm),
        .up       (up),
        .match    (match),
        .force_ev (force_ev),
        .force_om (force_om),
        .flag_clr (flag_clr),
        .port_out (port_out),
        .port_dir (port_dir),
        .flag     (flag),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

endmodule

// File: tb/sim_tmr_ocmp_top.sv
// Bench for tmr_ocmp_top: vector table in the up-counting modes, then directed
// tests for reset, force, buffering, PWM sweep and pin handover.
module sim_tmr_ocmp_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       port_out = 1'b1;
    logic       port_dir = 1'b1;
    logic       pin_out;
    logic       pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    tmr_ocmp_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_out(port_out), .port_dir(port_dir),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Fields: wm, om, cmp, start, ticks, exp count, exp flag, exp pin
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 2'd3, 8'd5, 8'd3,   8'd3, 8'd6, 1'b1, 1'b1},
        {2'd0, 2'd1, 8'd5, 8'd5,   8'd1, 8'd6, 1'b0, 1'b0},
        {2'd0, 2'd1, 8'd2, 8'd0,   8'd3, 8'd3, 1'b1, 1'b1},
        {2'd1, 2'd1, 8'd3, 8'd0,   8'd4, 8'd0, 1'b1, 1'b1},
        {2'd1, 2'd1, 8'd3, 8'd0,   8'd8, 8'd0, 1'b1, 1'b0},
        {2'd0, 2'd3, 8'd0, 8'd254, 8'd3, 8'd1, 1'b1, 1'b1},
        {2'd0, 2'd0, 8'd2, 8'd0,   8'd3, 8'd3, 1'b1, 1'b1},
        {2'd0, 2'd2, 8'd9, 8'd0,   8'd5, 8'd5, 1'b0, 1'b0}
    };

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk) begin reg_we = 1'b1; reg_addr = a; reg_wdata = d; end
        @(negedge clk) reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1 v = int'(reg_rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung expected finished");
        finish_run();
    end

    initial begin
        int v;

        // R1: reset state
        do_reset();
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1", "register after reset", v, 0);
        end
        check("R1", "pin follows port bit", int'(pin_out), 1);
        check("R9", "pin_oe follows direction", int'(pin_oe), 1);

        // Vector table: R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            logic [37:0] e;
            e = VEC[i];
            do_reset();
            wr(2'd0, {4'd0, e[35:34], e[37:36]});
            wr(2'd2, e[33:26]);
            wr(2'd1, e[25:18]);
            repeat (3) @(negedge clk);
            ticks(int'(e[17:10]));
            rd(2'd1, v);
            check("R2/R4 vec", "count", v, int'(e[9:2]));
            rd(2'd3, v);
            check("R3/R5 vec", "flag", v, int'(e[1]));
            check("R3/R9 vec", "pin", int'(pin_out), int'(e[0]));
        end

        // R6: force in normal mode sets the bit without flag or count change
        do_reset();
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'd7);
        wr(2'd0, 8'h8C);
        check("R6", "forced pin", int'(pin_out), 1);
        rd(2'd3, v);
        check("R6", "flag after force", v, 0);
        rd(2'd1, v);
        check("R6", "count after force", v, 7);
        rd(2'd0, v);
        check("R6", "control readback", v, 8'h0C);

        // R10: bit kept across a waveform mode change
        wr(2'd0, 8'h0D);
        check("R10", "pin after mode change", int'(pin_out), 1);

        // R9: output mode off hands pin back to port bit, direction drives oe
        port_out = 1'b0;
        wr(2'd0, 8'h01);
        check("R9", "pin from port bit", int'(pin_out), 0);
        port_dir = 1'b0;
        #1 check("R9", "pin_oe off", int'(pin_oe), 0);
        port_dir = 1'b1;
        port_out = 1'b1;

        // R6: force ignored in PWM
        do_reset();
        wr(2'd0, 8'h0E);
        wr(2'd0, 8'h8E);
        check("R6", "force in PWM", int'(pin_out), 0);

        // R8 and R7: buffered compare and PWM sweep through top
        do_reset();
        wr(2'd0, 8'h0A);
        wr(2'd2, 8'd252);
        rd(2'd2, v);
        check("R8", "buffer readback", v, 252);
        wr(2'd1, 8'd250);
        ticks(3);
        rd(2'd3, v);
        check("R8", "no match before reload", v, 0);
        rd(2'd1, v);
        check("R7", "count rising", v, 253);
        ticks(3);
        rd(2'd1, v);
        check("R7", "turn at top", v, 254);
        ticks(3);
        rd(2'd3, v);
        check("R8", "match after reload", v, 1);
        check("R7", "down-count sets bit", int'(pin_out), 1);
        rd(2'd1, v);
        check("R7", "count falling", v, 251);
        wr(2'd3, 8'h01);
        rd(2'd3, v);
        check("R3", "flag cleared", v, 0);

        // R5: block survives idle cycles with the timer stopped
        do_reset();
        wr(2'd0, 8'h04);
        wr(2'd2, 8'd4);
        wr(2'd1, 8'd4);
        repeat (10) @(negedge clk);
        ticks(1);
        rd(2'd3, v);
        check("R5", "blocked after idle", v, 0);
        rd(2'd1, v);
        check("R5", "count after blocked tick", v, 5);

        finish_run();
    end

endmodule